// File: doc/BRIEF.md
# SDRAM Bank State Tracking Monitor

This block watches the command bus of a single-data-rate SDRAM without driving it. On every clock edge it decodes the command formed by chip select, row strobe, column strobe and write enable, and it moves a small state machine for each bank accordingly. The per-bank states are idle, opening a row, row open, read burst, write burst, read or write burst that closes itself, and closing. A device-wide tracker covers the states that lock the whole part: auto refresh, mode register load and close-all.

Each timed window is counted in clock cycles from parameters. These are the row close time, the row open time, the refresh cycle time, the mode load time and the burst length. A command that is not allowed in the state it meets is reported one cycle later as a violation pulse with a cause code. An offending command is not applied to the tracked state. Bus edges where the clock enable was not high on both the previous and the current edge are not checked and not applied. The block is meant to sit beside a memory controller in simulation or in silicon as a protocol watchdog. Its bank and device state outputs also serve as a live view of the memory.

Top module: `sdram_bank_monitor`

## Requirements
- R1: Commands are decoded from active-low {cs_n, ras_n, cas_n, we_n}. cs_n=1 is inhibit, regardless of the other three lines. With cs_n=0, the {ras_n,cas_n,we_n} values decode as follows: 111 no-op, 011 open row, 101 read, 100 write, 010 close, 001 auto refresh, 000 mode load, 110 burst stop. Inhibit and no-op never raise a violation.
- R2: An open-row command to an idle bank puts it in opening state (bank code 1) for T_RCD cycles. Any other bank command to that bank during that window is reported with code 3 (bank busy). From the T_RCD-th edge on, the bank reports row open (code 2).
- R3: A close command with a10=0 to a bank that is not idle puts that bank in closing state (code 7). The bank becomes idle (code 0) so that a command on the T_RP-th edge after the close is legal. Bank commands inside the window get code 3. A close to an idle bank is legal and leaves it idle.
- R4: An open-row command to a bank that is not idle is reported with code 4. A read or write to an idle bank is reported with code 5.
- R5: Auto refresh holds the device busy for T_RC cycles, mode load for T_MRD cycles and close-all for T_RP cycles. Inside the window, every command other than inhibit or no-op gets code 1. The device state output reads 0 idle, 1 refresh, 2 mode load, 3 close-all.
- R6: Auto refresh and mode load with any bank not idle are reported with code 2.
- R7: A read or write with a10=1 puts the bank in self-closing burst state (5 read, 6 write) for BL cycles. After that the bank is closing for T_RP cycles and then idle. Commands to the bank during the whole span get code 3.
- R8: A read or write with a10=0 (code 3 read, 4 write) returns the bank to row open after BL cycles. A read or write to another bank ends such a burst at once, back to row open. The same cross-bank access starts the closing window of a self-closing burst at once.
- R9: Burst stop ends the most recently started read or write burst, whatever the bank address lines carry.
- R10: Close-all (close with a10=1) is reported with code 6 when any bank is opening, closing or in a self-closing burst. Otherwise every non-idle bank enters closing and the device enters close-all state.
- R11: A command is checked and applied only when cke was high on the previous edge and is high on the current edge. Otherwise it is ignored.
- R12: A violation sets viol_o and viol_code_o in the cycle after the offending edge. The rejected command changes no bank or device state. viol_code_o is 0 when no violation occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank address |
| a10 | input | 1 | Self-close on read/write, all banks on close |
| viol_o | output | 1 | Violation pulse for the previous edge |
| viol_code_o | output | 3 | Violation cause, 0 when none |
| bank_state_o | output | 3*NUM_BANKS | Current state of each bank, bank i at bits [3i+2:3i] |
| dev_state_o | output | 2 | Device-wide state |

## Verification
The bench places commands on the exact edges where each timing window ends: one edge early must be flagged, and the edge that meets the window must pass. A window counter that is one cycle long or short therefore shows up as a missing or spurious busy code. Cross-bank interruption is checked on a burst without self-close and on a self-closing one. A monitor that ignored interruption would leave a bank in a burst state or let a self-closing bank reopen too soon. The bench also checks a burst stop with an unrelated bank address, close-all refused while a row is still opening, and inhibit with all other lines low during a refresh. The clock-enable gate is probed with a bad read on edges where cke is low or was low just before; a monitor that checked those edges would flag them.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
        CMD_PRE, CMD_REF, CMD_LMR, CMD_BST
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE        = 3'd0,
        BK_ACTIVATING  = 3'd1,
        BK_ACTIVE      = 3'd2,
        BK_READ        = 3'd3,
        BK_WRITE       = 3'd4,
        BK_READ_AP     = 3'd5,
        BK_WRITE_AP    = 3'd6,
        BK_PRECHARGING = 3'd7
    } bank_st_e;

    typedef enum logic [1:0] {
        DEV_IDLE    = 2'd0,
        DEV_REFRESH = 2'd1,
        DEV_MODE    = 2'd2,
        DEV_PREALL  = 2'd3
    } dev_st_e;

    typedef enum logic [2:0] {
        VC_NONE        = 3'd0,
        VC_DEV_BUSY    = 3'd1,
        VC_NOT_IDLE    = 3'd2,
        VC_BANK_BUSY   = 3'd3,
        VC_ROW_OPEN    = 3'd4,
        VC_NO_ROW      = 3'd5,
        VC_PREALL_BUSY = 3'd6
    } viol_e;

    // States that no command aimed at the bank may interrupt
    function automatic logic bank_locked(input bank_st_e s);
        return (s == BK_ACTIVATING) || (s == BK_PRECHARGING) ||
               (s == BK_READ_AP) || (s == BK_WRITE_AP);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd_o
);

    always_comb begin
        if (cs_n) begin
            cmd_o = CMD_INHIBIT;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd_o = CMD_NOP;
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = CMD_REF;
                3'b000:  cmd_o = CMD_LMR;
                default: cmd_o = CMD_BST;
            endcase
        end
    end

endmodule

// File: rtl/sdram_legality.sv
module sdram_legality
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input  cmd_e                    cmd_i,
    input  logic [BA_W-1:0]         ba_i,
    input  logic                    a10_i,
    input  logic                    dev_busy_i,
    input  logic [NUM_BANKS*3-1:0]  st_i,
    output viol_e                   code_o
);

    logic     all_idle;
    logic     any_locked;
    bank_st_e tgt;

    always_comb begin
        all_idle   = 1'b1;
        any_locked = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_st_e'(st_i[i*3 +: 3]) != BK_IDLE) all_idle = 1'b0;
            if (bank_locked(bank_st_e'(st_i[i*3 +: 3]))) any_locked = 1'b1;
        end
        tgt = bank_st_e'(st_i[int'(ba_i)*3 +: 3]);

        code_o = VC_NONE;
        if (cmd_i == CMD_INHIBIT || cmd_i == CMD_NOP) begin
            code_o = VC_NONE;
        end else if (dev_busy_i) begin
            code_o = VC_DEV_BUSY;
        end else begin
            case (cmd_i)
                CMD_REF, CMD_LMR: if (!all_idle) code_o = VC_NOT_IDLE;
                CMD_PRE: begin
                    if (a10_i) begin
                        if (any_locked) code_o = VC_PREALL_BUSY;
                    end else if (bank_locked(tgt)) begin
                        code_o = VC_BANK_BUSY;
                    end
                end
                CMD_ACT: begin
                    if (bank_locked(tgt))    code_o = VC_BANK_BUSY;
                    else if (tgt != BK_IDLE) code_o = VC_ROW_OPEN;
                end
                CMD_RD, CMD_WR: begin
                    if (bank_locked(tgt))    code_o = VC_BANK_BUSY;
                    else if (tgt == BK_IDLE) code_o = VC_NO_ROW;
                end
                default: code_o = VC_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_mon_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int T_RP  = 3,
    parameter int T_RCD = 3,
    parameter int BL    = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     apply_i,
    input  cmd_e     cmd_i,
    input  logic     hit_i,
    input  logic     a10_i,
    input  logic     bst_hit_i,
    output bank_st_e st_o
);

    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] BL_LD  = CNT_W'(BL - 1);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
    } bank_reg_t;

    bank_reg_t r_d, r_q;
    bank_st_e  st_eff;

    // A timed window whose counter reached zero has already been met
    always_comb begin
        st_eff = r_q.st;
        if (r_q.cnt == '0) begin
            if (r_q.st == BK_PRECHARGING)     st_eff = BK_IDLE;
            else if (r_q.st == BK_ACTIVATING) st_eff = BK_ACTIVE;
        end
    end

    assign st_o = st_eff;

    always_comb begin
        r_d.st  = st_eff;
        r_d.cnt = r_q.cnt;
        case (st_eff)
            BK_PRECHARGING, BK_ACTIVATING: r_d.cnt = r_q.cnt - CNT_W'(1);
            BK_READ, BK_WRITE: begin
                if (r_q.cnt == '0) r_d.st  = BK_ACTIVE;
                else               r_d.cnt = r_q.cnt - CNT_W'(1);
            end
            BK_READ_AP, BK_WRITE_AP: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = BK_PRECHARGING;
                    r_d.cnt = RP_LD;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: ;
        endcase

        if (apply_i) begin
            case (cmd_i)
                CMD_ACT: begin
                    if (hit_i) begin
                        r_d.st  = BK_ACTIVATING;
                        r_d.cnt = RCD_LD;
                    end
                end
                CMD_RD, CMD_WR, CMD_BST: begin
                    if (hit_i && cmd_i != CMD_BST) begin
                        if (cmd_i == CMD_RD) r_d.st = a10_i ? BK_READ_AP : BK_READ;
                        else                 r_d.st = a10_i ? BK_WRITE_AP : BK_WRITE;
                        r_d.cnt = BL_LD;
                    end else if ((cmd_i != CMD_BST) || bst_hit_i) begin
                        // burst cut short by another access or by burst stop
                        if (st_eff == BK_READ || st_eff == BK_WRITE) begin
                            r_d.st  = BK_ACTIVE;
                            r_d.cnt = '0;
                        end else if (st_eff == BK_READ_AP || st_eff == BK_WRITE_AP) begin
                            r_d.st  = BK_PRECHARGING;
                            r_d.cnt = RP_LD;
                        end
                    end
                end
                CMD_PRE: begin
                    if ((hit_i || a10_i) && st_eff != BK_IDLE) begin
                        r_d.st  = BK_PRECHARGING;
                        r_d.cnt = RP_LD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R7: a self-closing burst never goes back to an open row
    assert_ap_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BK_READ_AP || r_q.st == BK_WRITE_AP) |=>
        (r_q.st == BK_READ_AP || r_q.st == BK_WRITE_AP || r_q.st == BK_PRECHARGING));

    // R2: an open row is only reached through opening or a plain burst
    assert_open_via_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BK_ACTIVE && $past(r_q.st) != BK_ACTIVE) |->
        ($past(r_q.st) == BK_ACTIVATING || $past(r_q.st) == BK_READ ||
         $past(r_q.st) == BK_WRITE));

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BL        = 4,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 3,
    parameter int T_RC      = 8,
    parameter int T_MRD     = 2,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    output logic                   viol_o,
    output logic [2:0]             viol_code_o,
    output logic [NUM_BANKS*3-1:0] bank_state_o,
    output logic [1:0]             dev_state_o
);

    localparam int T_M1  = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int T_M2  = (T_RC > T_MRD) ? T_RC : T_MRD;
    localparam int T_M3  = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int T_MAX = (T_M3 > BL) ? T_M3 : BL;
    localparam int CNT_W = $clog2(T_MAX + 1);

    localparam logic [CNT_W-1:0] RC_LD  = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);

    typedef struct packed {
        logic             cke_prev;
        dev_st_e          dev;
        logic [CNT_W-1:0] dcnt;
        logic [BA_W-1:0]  last_bank;
        logic             viol;
        viol_e            code;
    } mon_reg_t;

    mon_reg_t               r_d, r_q;
    cmd_e                   cmd;
    viol_e                  code;
    dev_st_e                dev_cur;
    logic                   cke_ok;
    logic                   apply;
    logic [NUM_BANKS*3-1:0] bank_flat;

    sdram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd_o (cmd)
    );

    assign dev_cur = (r_q.dev != DEV_IDLE && r_q.dcnt == '0) ? DEV_IDLE : r_q.dev;
    assign cke_ok  = r_q.cke_prev && cke;

    sdram_legality #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W)
    ) u_legal (
        .cmd_i      (cmd),
        .ba_i       (ba),
        .a10_i      (a10),
        .dev_busy_i (dev_cur != DEV_IDLE),
        .st_i       (bank_flat),
        .code_o     (code)
    );

    assign apply = cke_ok && (code == VC_NONE) &&
                   (cmd != CMD_INHIBIT) && (cmd != CMD_NOP);

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        bank_st_e st_w;
        sdram_bank_fsm #(
            .CNT_W (CNT_W),
            .T_RP  (T_RP),
            .T_RCD (T_RCD),
            .BL    (BL)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .apply_i   (apply),
            .cmd_i     (cmd),
            .hit_i     (ba == BA_W'(gi)),
            .a10_i     (a10),
            .bst_hit_i (r_q.last_bank == BA_W'(gi)),
            .st_o      (st_w)
        );
        assign bank_flat[gi*3 +: 3] = st_w;
    end

    always_comb begin
        r_d          = r_q;
        r_d.cke_prev = cke;
        r_d.dev      = dev_cur;
        if (dev_cur != DEV_IDLE) r_d.dcnt = r_q.dcnt - CNT_W'(1);
        if (apply) begin
            case (cmd)
                CMD_REF: begin
                    r_d.dev  = DEV_REFRESH;
                    r_d.dcnt = RC_LD;
                end
                CMD_LMR: begin
                    r_d.dev  = DEV_MODE;
                    r_d.dcnt = MRD_LD;
                end
                CMD_PRE: begin
                    if (a10) begin
                        r_d.dev  = DEV_PREALL;
                        r_d.dcnt = RP_LD;
                    end
                end
                CMD_RD, CMD_WR: r_d.last_bank = ba;
                default: ;
            endcase
        end
        r_d.viol = cke_ok && (code != VC_NONE);
        r_d.code = cke_ok ? code : VC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign viol_o       = r_q.viol;
    assign viol_code_o  = r_q.code;
    assign bank_state_o = bank_flat;
    assign dev_state_o  = dev_cur;

    // R11: edges without cke high twice never report
    assert_cke_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.cke_prev && cke) |=> !viol_o);

    // R5: a locked device rejects every executable command
    assert_dev_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_cur != DEV_IDLE && cke_ok && cmd != CMD_INHIBIT && cmd != CMD_NOP) |=>
        (viol_o && viol_code_o == VC_DEV_BUSY));

    // R6: refresh and mode load need every bank idle
    assert_all_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_ok && dev_cur == DEV_IDLE && (cmd == CMD_REF || cmd == CMD_LMR) &&
         bank_flat != '0) |=> (viol_o && viol_code_o == VC_NOT_IDLE));

    // R12: a reported violation always carries a cause
    assert_code_with_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_ok && cmd != CMD_INHIBIT && cmd != CMD_NOP && !apply) |=>
        (viol_o && viol_code_o != VC_NONE));

endmodule

// File: tb/sdram_bank_monitor_tb.sv
module sdram_bank_monitor_tb;

    localparam int NB   = 4;
    localparam int BLEN = 4;
    localparam int TRP  = 3;
    localparam int TRCD = 2;
    localparam int TRC  = 5;
    localparam int TMRD = 2;

    localparam logic [2:0] K_NOP = 3'b111;
    localparam logic [2:0] K_ACT = 3'b011;
    localparam logic [2:0] K_RD  = 3'b101;
    localparam logic [2:0] K_WR  = 3'b100;
    localparam logic [2:0] K_PRE = 3'b010;
    localparam logic [2:0] K_REF = 3'b001;
    localparam logic [2:0] K_LMR = 3'b000;
    localparam logic [2:0] K_BST = 3'b110;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cke;
    logic          cs_n, ras_n, cas_n, we_n;
    logic [1:0]    ba;
    logic          a10;
    logic          viol_o;
    logic [2:0]    viol_code_o;
    logic [NB*3-1:0] bank_state_o;
    logic [1:0]    dev_state_o;

    always #2 clk = ~clk;

    sdram_bank_monitor #(
        .NUM_BANKS (NB), .BL (BLEN), .T_RP (TRP),
        .T_RCD (TRCD), .T_RC (TRC), .T_MRD (TMRD)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ba (ba), .a10 (a10),
        .viol_o (viol_o), .viol_code_o (viol_code_o),
        .bank_state_o (bank_state_o), .dev_state_o (dev_state_o)
    );

    typedef struct {
        logic [2:0] code;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;

    task automatic step(input logic cs, input logic [2:0] rcw, input int b,
                        input logic a, input logic [2:0] exp_code, input string tag);
        exp_t e;
        @(negedge clk);
        cs_n = cs;
        {ras_n, cas_n, we_n} = rcw;
        ba  = b[1:0];
        a10 = a;
        @(posedge clk);
        #1;
        e.code = exp_code;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic cmd(input logic [2:0] rcw, input int b, input logic a,
                       input logic [2:0] exp_code, input string tag);
        step(1'b0, rcw, b, a, exp_code, tag);
    endtask

    task automatic nop(input string tag);
        step(1'b0, K_NOP, 0, 1'b0, 3'd0, tag);
    endtask

    task automatic check_bank(input int b, input logic [2:0] exp_st, input string tag);
        logic [2:0] got;
        got = bank_state_o[b*3 +: 3];
        checks++;
        if (got !== exp_st) begin
            failures++;
            $display("FAIL %s bank%0d state actual=%0d expected=%0d", tag, b, got, exp_st);
        end
    endtask

    task automatic check_dev(input logic [1:0] exp_st, input string tag);
        checks++;
        if (dev_state_o !== exp_st) begin
            failures++;
            $display("FAIL %s device state actual=%0d expected=%0d", tag, dev_state_o, exp_st);
        end
    endtask

    // scoreboard monitor: one expected report per driven edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (viol_o !== (e.code != 3'd0) || viol_code_o !== e.code) begin
                failures++;
                $display("FAIL %s violation actual=%0b/%0d expected=%0b/%0d",
                         e.tag, viol_o, viol_code_o, (e.code != 3'd0), e.code);
            end
        end
    end

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cke = 1'b0; cs_n = 1'b1;
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = 2'd0; a10 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (viol_o !== 1'b0 || viol_code_o !== 3'd0) begin
            failures++;
            $display("FAIL R12 reset violation actual=%0b/%0d expected=0/0", viol_o, viol_code_o);
        end
        for (int i = 0; i < NB; i++) check_bank(i, 3'd0, "R3 reset");
        check_dev(2'd0, "R5 reset");

        // R11: clock enable gating
        cmd(K_RD, 0, 1'b0, 3'd0, "R11 cke low");
        check_bank(0, 3'd0, "R11");
        cke = 1'b1;
        cmd(K_RD, 0, 1'b0, 3'd0, "R11 cke was low");
        check_bank(0, 3'd0, "R11");

        // R4 / R12: read to idle bank rejected, not applied
        cmd(K_RD, 0, 1'b0, 3'd5, "R4 read idle");
        check_bank(0, 3'd0, "R12 not applied");

        // R2: open row timing
        cmd(K_ACT, 0, 1'b0, 3'd0, "R2 act");
        check_bank(0, 3'd1, "R2 opening");
        cmd(K_RD, 0, 1'b0, 3'd3, "R2 read too early");
        check_bank(0, 3'd2, "R2 open");
        cmd(K_ACT, 0, 1'b0, 3'd4, "R4 act open");
        check_bank(0, 3'd2, "R4");

        // R8: plain burst length
        cmd(K_RD, 0, 1'b0, 3'd0, "R8 read");
        check_bank(0, 3'd3, "R8 reading");
        nop("R8"); nop("R8"); nop("R8");
        check_bank(0, 3'd3, "R8 still reading");
        nop("R8");
        check_bank(0, 3'd2, "R8 burst done");

        // R8: cross-bank interruption
        cmd(K_ACT, 1, 1'b0, 3'd0, "R8 act b1");
        nop("R8");
        cmd(K_WR, 0, 1'b0, 3'd0, "R8 write b0");
        check_bank(0, 3'd4, "R8 writing");
        cmd(K_RD, 1, 1'b1, 3'd0, "R7 read ap b1");
        check_bank(0, 3'd2, "R8 write cut");
        check_bank(1, 3'd5, "R7 read ap");
        cmd(K_RD, 0, 1'b0, 3'd0, "R8 read b0");
        check_bank(1, 3'd7, "R8 ap cut starts close");
        check_bank(0, 3'd3, "R8");
        cmd(K_ACT, 1, 1'b0, 3'd3, "R7 act while closing");
        nop("R3");
        check_bank(1, 3'd0, "R3 closed");

        // R9: burst stop with unrelated bank address
        cmd(K_BST, 2, 1'b0, 3'd0, "R9 bst");
        check_bank(0, 3'd2, "R9 burst stopped");

        // R7: full self-closing write
        cmd(K_WR, 0, 1'b1, 3'd0, "R7 write ap");
        nop("R7"); nop("R7"); nop("R7");
        check_bank(0, 3'd6, "R7 ap burst");
        nop("R7");
        check_bank(0, 3'd7, "R7 ap closing");
        cmd(K_PRE, 0, 1'b0, 3'd3, "R7 pre while closing");
        nop("R7");
        check_bank(0, 3'd0, "R7 idle");

        // R3: close timing and close of idle bank
        cmd(K_ACT, 2, 1'b0, 3'd0, "R3 act b2");
        nop("R3");
        cmd(K_PRE, 2, 1'b0, 3'd0, "R3 pre b2");
        check_bank(2, 3'd7, "R3 closing");
        cmd(K_PRE, 3, 1'b0, 3'd0, "R3 pre idle b3");
        check_bank(3, 3'd0, "R3 idle stays idle");
        cmd(K_ACT, 2, 1'b0, 3'd3, "R3 act one edge early");
        check_bank(2, 3'd0, "R3 idle at tRP");
        cmd(K_ACT, 2, 1'b0, 3'd0, "R3 act at tRP");

        // R10: close-all
        cmd(K_PRE, 0, 1'b1, 3'd6, "R10 pre all while opening");
        check_dev(2'd0, "R10 refused");
        cmd(K_ACT, 3, 1'b0, 3'd0, "R10 act b3");
        nop("R10");
        cmd(K_PRE, 0, 1'b1, 3'd0, "R10 pre all");
        check_dev(2'd3, "R10 device");
        check_bank(2, 3'd7, "R10 b2");
        check_bank(3, 3'd7, "R10 b3");
        check_bank(0, 3'd0, "R10 b0");
        cmd(K_ACT, 0, 1'b0, 3'd1, "R5 act during pre all");
        step(1'b1, K_LMR, 0, 1'b0, 3'd0, "R1 inhibit");
        check_dev(2'd0, "R5 pre all done");
        check_bank(2, 3'd0, "R10 b2 idle");

        // R6: refresh and mode load need idle banks
        cmd(K_ACT, 1, 1'b0, 3'd0, "R6 act b1");
        cmd(K_LMR, 0, 1'b0, 3'd2, "R6 mode with open bank");
        check_dev(2'd0, "R6");
        cmd(K_PRE, 1, 1'b0, 3'd0, "R6 pre b1");
        nop("R6"); nop("R6");

        // R5: refresh window
        cmd(K_REF, 0, 1'b0, 3'd0, "R5 refresh");
        check_dev(2'd1, "R5 refreshing");
        cmd(K_LMR, 0, 1'b0, 3'd1, "R5 mode during refresh");
        step(1'b1, K_LMR, 0, 1'b0, 3'd0, "R1 inhibit in refresh");
        nop("R1");
        check_dev(2'd1, "R5 still refreshing");
        nop("R5");
        check_dev(2'd0, "R5 refresh done");

        // R5: mode load window
        cmd(K_LMR, 0, 1'b0, 3'd0, "R5 mode load");
        check_dev(2'd2, "R5 mode");
        cmd(K_ACT, 0, 1'b0, 3'd1, "R5 act during mode");
        check_dev(2'd0, "R5 mode done");
        cmd(K_ACT, 0, 1'b0, 3'd0, "R5 act after mode");
        check_bank(0, 3'd1, "R5");
        cmd(K_REF, 0, 1'b0, 3'd2, "R6 refresh with open bank");

        nop("R1"); nop("R1");
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule